// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block is a small bus-master sequencer that works out which parallel NOR flash device sits on a word-wide bus. It runs once after reset leaves, and again whenever `start_i` is pulsed while it is idle.

Each run follows the same order:

- It sends an autoselect command sequence that both command families accept. Parts driven through unlock cycles need the two unlock writes. Parts driven through a status register treat those writes as no-ops.
- It waits a configurable settle time.
- It reads the manufacturer code, and then the device code.

From these codes it reports four results: the command family, the sector count, the total size in bytes and a boot-block flag. A recognised part is then put back into read-array mode, using the reset command that suits its family. An unrecognised part gets no reset command.

Command bytes are placed in the low byte of every 16-bit half of the bus word, and the high byte of each half is zero. On a 32-bit bus made of two 16-bit devices, a device code matches only when it appears in both halves, and the reported size is doubled. The bus has single-cycle strobes. Read data must be valid in the cycle that follows a read strobe.

Top module: `nor_id_probe`

## Requirements
- R1: While reset is held, `busy_o` is 1. `done_o`, `bus_we_o` and `bus_re_o` are 0. `fam_o` is 0, `sectors_o` is 0, `size_o` is 0 and `boot_o` is 0. When reset is released, a probe starts without a start pulse.
- R2: A probe begins with three writes on consecutive cycles, in this order: byte 0xAA to word offset 0x555, byte 0x55 to offset 0x2AA, then byte 0x90 to offset 0x555. On a 16-bit bus the byte appears as 0x00XX. `bus_we_o` and `bus_re_o` are never high together.
- R3: The read of offset 0 occurs exactly SETTLE_CYC+1 cycles after the 0x90 write. No strobe occurs in between.
- R4: Only the low byte of the word read at offset 0 selects the vendor. Value 0x01 selects the unlock-cycle family (`fam_o`=1). Value 0x89 selects the status-register family (`fam_o`=2). The upper byte is ignored.
- R5: Any other manufacturer byte ends the probe with `fam_o`=0, `sectors_o`=0, `size_o`=0 and `boot_o`=0. In that case offset 1 is not read and no reset command is written.
- R6: The full word read at offset 1 is looked up in the device table. The default table holds these entries:

  | Device code | Sectors | Size (bytes) | Boot-block |
  |---|---|---|---|
  | 0x22D7 | 128 | 2^23 | 0 |
  | 0x88C1 | 23 | 2^20 | 1 |
  | 0x88C2 | 39 | 2^21 | 1 |
  | 0x88C3 | 71 | 2^22 | 1 |
  | 0x88C4 | 135 | 2^23 | 1 |

  The size applies on a 16-bit bus.
- R7: An unmatched device code gives the unknown result of R5. No reset command is written.
- R8: After a matched device code, one write to offset 0 returns the part to read-array mode. The byte is 0xF0 for `fam_o`=1 and 0xFF for `fam_o`=2.
- R9: `done_o` is a one-cycle pulse, and `busy_o` is 0 in that cycle. The results change only in the cycle where `done_o` is high, and hold until the next `done_o`.
- R10: A start pulse while `busy_o` is 1 is ignored. A start pulse while idle launches a new probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a new probe (used only when idle) |
| bus_addr_o | output | ADDR_W | Flash word address |
| bus_wdata_o | output | BUS_W | Flash write data |
| bus_rdata_i | input | BUS_W | Flash read data, valid the cycle after a read strobe |
| bus_we_o | output | 1 | Single-cycle write strobe |
| bus_re_o | output | 1 | Single-cycle read strobe |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fam_o | output | 2 | 0 unknown, 1 unlock-cycle family, 2 status-register family |
| sectors_o | output | 8 | Sector count of the detected part |
| size_o | output | SIZE_W | Total size in bytes |
| boot_o | output | 1 | Detected part has boot-block sectors |

## Verification
The bench goes after the paths where the two command families part ways:

- **Reset command.** A design that picked the reset byte from the wrong family would write 0xF0 to a status-register part. The bus-event scoreboard catches this.
- **Manufacturer byte with a junk upper byte.** A design comparing the whole word would misreport the part as unknown.
- **Unknown vendor or unmatched device code, including a code one off from a table entry.** A design that still issued a reset write, or read offset 1 after a vendor miss, shows up as an unexpected strobe.
- **Settle timing.** An off-by-one in the settle counter moves the read of offset 0 by a cycle.
- **Start pulse in the middle of a probe.** If it were honoured, the command writes would restart in place of the expected ID read.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

    typedef enum logic [1:0] {
        FAM_NONE   = 2'd0,
        FAM_UNLOCK = 2'd1,
        FAM_STATUS = 2'd2
    } fam_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_UNLK1,
        ST_UNLK2,
        ST_AUTOSEL,
        ST_SETTLE,
        ST_RD_MFR,
        ST_CAP_MFR,
        ST_RD_DEV,
        ST_CAP_DEV,
        ST_RDMODE,
        ST_DONE
    } probe_st_e;

    localparam int CODE_W    = 16;
    localparam int SEC_W     = 8;
    localparam int LG_W      = 5;
    localparam int DEV_ENT_W = CODE_W + SEC_W + LG_W + 1;

    localparam int OFF_UNLK_A = 'h555;
    localparam int OFF_UNLK_B = 'h2AA;
    localparam int OFF_MFR    = 0;
    localparam int OFF_DEV    = 1;

    localparam logic [7:0] CMD_UNLK_A    = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B    = 8'h55;
    localparam logic [7:0] CMD_AUTOSEL   = 8'h90;
    localparam logic [7:0] CMD_RD_STATUS = 8'hFF;
    localparam logic [7:0] CMD_RD_UNLOCK = 8'hF0;

    // Packs one device-table entry: {code, sectors, log2 size at 16-bit bus, boot}
    function automatic logic [DEV_ENT_W-1:0] dev_ent(
        input logic [CODE_W-1:0] code,
        input logic [SEC_W-1:0]  sec,
        input logic [LG_W-1:0]   lg,
        input logic              boot
    );
        return {code, sec, lg, boot};
    endfunction

endpackage

// File: rtl/nor_word_repl.sv
// Places a narrow value, zero-extended to 16 bits, into every 16-bit lane of a bus word.
module nor_word_repl #(
    parameter int BUS_W = 16,
    parameter int IN_W  = 8
) (
    input  logic [IN_W-1:0]  in_i,
    output logic [BUS_W-1:0] word_o
);
    localparam int LANES = BUS_W / 16;

    logic [15:0] lane;
    assign lane = 16'(in_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*16 +: 16] = lane;
    end

endmodule

// File: rtl/nor_dev_match.sv
// Looks up a full bus word in the device table; the lowest index wins on a tie.
module nor_dev_match
    import nor_probe_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int NUM_DEV = 5,
    parameter logic [NUM_DEV*DEV_ENT_W-1:0] DEV_TABLE = '0
) (
    input  logic [BUS_W-1:0] word_i,
    output logic             hit_o,
    output logic [SEC_W-1:0] sectors_o,
    output logic [LG_W-1:0]  lg_o,
    output logic             boot_o
);
    logic [NUM_DEV-1:0] hit_vec;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_ent
        localparam logic [DEV_ENT_W-1:0] ENT = DEV_TABLE[g*DEV_ENT_W +: DEV_ENT_W];
        logic [BUS_W-1:0] code_word;

        nor_word_repl #(.BUS_W(BUS_W), .IN_W(CODE_W)) u_code_repl (
            .in_i   (ENT[DEV_ENT_W-1 -: CODE_W]),
            .word_o (code_word)
        );

        assign hit_vec[g] = (word_i == code_word);
    end

    always_comb begin
        logic [DEV_ENT_W-1:0] sel;
        sel   = '0;
        hit_o = 1'b0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel   = DEV_TABLE[i*DEV_ENT_W +: DEV_ENT_W];
                hit_o = 1'b1;
            end
        end
        sectors_o = sel[LG_W+1 +: SEC_W];
        lg_o      = sel[1 +: LG_W];
        boot_o    = sel[0];
    end

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
    import nor_probe_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int ADDR_W     = 24,
    parameter int SETTLE_CYC = 5000,
    parameter int SIZE_W     = 32,
    parameter logic [7:0] VEND_UNLOCK = 8'h01,
    parameter logic [7:0] VEND_STATUS = 8'h89,
    parameter int NUM_DEV    = 5,
    parameter logic [NUM_DEV*DEV_ENT_W-1:0] DEV_TABLE = {
        dev_ent(16'h88C4, 8'd135, 5'd23, 1'b1),
        dev_ent(16'h88C3, 8'd71,  5'd22, 1'b1),
        dev_ent(16'h88C2, 8'd39,  5'd21, 1'b1),
        dev_ent(16'h88C1, 8'd23,  5'd20, 1'b1),
        dev_ent(16'h22D7, 8'd128, 5'd23, 1'b0)
    }
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [BUS_W-1:0]  bus_wdata_o,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    output logic              bus_we_o,
    output logic              bus_re_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        fam_o,
    output logic [SEC_W-1:0]  sectors_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              boot_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [LG_W:0]    WIDE_ADJ    = (BUS_W == 32) ? 1 : 0;

    typedef struct packed {
        probe_st_e         st;
        logic [CNT_W-1:0]  cnt;
        fam_e              fam_pend;
        logic [SEC_W-1:0]  sec_pend;
        logic [LG_W-1:0]   lg_pend;
        logic              boot_pend;
        fam_e              res_fam;
        logic [SEC_W-1:0]  res_sec;
        logic [SIZE_W-1:0] res_size;
        logic              res_boot;
    } probe_regs_t;

    probe_regs_t r_q, r_d;

    logic [7:0]       cmd_byte;
    logic             dev_hit;
    logic [SEC_W-1:0] dev_sec;
    logic [LG_W-1:0]  dev_lg;
    logic             dev_boot;
    logic [LG_W:0]    size_shift;

    nor_dev_match #(
        .BUS_W     (BUS_W),
        .NUM_DEV   (NUM_DEV),
        .DEV_TABLE (DEV_TABLE)
    ) u_match (
        .word_i    (bus_rdata_i),
        .hit_o     (dev_hit),
        .sectors_o (dev_sec),
        .lg_o      (dev_lg),
        .boot_o    (dev_boot)
    );

    nor_word_repl #(.BUS_W(BUS_W), .IN_W(8)) u_cmd_repl (
        .in_i   (cmd_byte),
        .word_o (bus_wdata_o)
    );

    assign size_shift = {1'b0, r_q.lg_pend} + WIDE_ADJ;

    always_comb begin
        r_d        = r_q;
        cmd_byte   = 8'h00;
        bus_we_o   = 1'b0;
        bus_re_o   = 1'b0;
        bus_addr_o = '0;

        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                r_d.st = start_i ? ST_LAUNCH : ST_IDLE;
            end
            ST_LAUNCH: begin
                r_d.st = ST_UNLK1;
            end
            ST_UNLK1: begin
                bus_we_o   = 1'b1;
                bus_addr_o = ADDR_W'(OFF_UNLK_A);
                cmd_byte   = CMD_UNLK_A;
                r_d.st     = ST_UNLK2;
            end
            ST_UNLK2: begin
                bus_we_o   = 1'b1;
                bus_addr_o = ADDR_W'(OFF_UNLK_B);
                cmd_byte   = CMD_UNLK_B;
                r_d.st     = ST_AUTOSEL;
            end
            ST_AUTOSEL: begin
                bus_we_o   = 1'b1;
                bus_addr_o = ADDR_W'(OFF_UNLK_A);
                cmd_byte   = CMD_AUTOSEL;
                r_d.cnt    = '0;
                r_d.st     = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (r_q.cnt == SETTLE_LAST) begin
                    r_d.st = ST_RD_MFR;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_RD_MFR: begin
                bus_re_o   = 1'b1;
                bus_addr_o = ADDR_W'(OFF_MFR);
                r_d.st     = ST_CAP_MFR;
            end
            ST_CAP_MFR: begin
                if (bus_rdata_i[7:0] == VEND_UNLOCK) begin
                    r_d.fam_pend = FAM_UNLOCK;
                    r_d.st       = ST_RD_DEV;
                end else if (bus_rdata_i[7:0] == VEND_STATUS) begin
                    r_d.fam_pend = FAM_STATUS;
                    r_d.st       = ST_RD_DEV;
                end else begin
                    r_d.res_fam  = FAM_NONE;
                    r_d.res_sec  = '0;
                    r_d.res_size = '0;
                    r_d.res_boot = 1'b0;
                    r_d.st       = ST_DONE;
                end
            end
            ST_RD_DEV: begin
                bus_re_o   = 1'b1;
                bus_addr_o = ADDR_W'(OFF_DEV);
                r_d.st     = ST_CAP_DEV;
            end
            ST_CAP_DEV: begin
                if (dev_hit) begin
                    r_d.sec_pend  = dev_sec;
                    r_d.lg_pend   = dev_lg;
                    r_d.boot_pend = dev_boot;
                    r_d.st        = ST_RDMODE;
                end else begin
                    r_d.res_fam  = FAM_NONE;
                    r_d.res_sec  = '0;
                    r_d.res_size = '0;
                    r_d.res_boot = 1'b0;
                    r_d.st       = ST_DONE;
                end
            end
            ST_RDMODE: begin
                bus_we_o     = 1'b1;
                bus_addr_o   = ADDR_W'(OFF_MFR);
                cmd_byte     = (r_q.fam_pend == FAM_STATUS) ? CMD_RD_STATUS : CMD_RD_UNLOCK;
                r_d.res_fam  = r_q.fam_pend;
                r_d.res_sec  = r_q.sec_pend;
                r_d.res_size = SIZE_W'(1) << size_shift;
                r_d.res_boot = r_q.boot_pend;
                r_d.st       = ST_DONE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_LAUNCH;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE) && (r_q.st != ST_DONE);
    assign done_o    = (r_q.st == ST_DONE);
    assign fam_o     = r_q.res_fam;
    assign sectors_o = r_q.res_sec;
    assign size_o    = r_q.res_size;
    assign boot_o    = r_q.res_boot;

endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
    parameter int BUS_W      = 16,
    parameter int ADDR_W     = 24,
    parameter int SETTLE_CYC = 5000,
    parameter int SIZE_W     = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we_o,
    input logic              bus_re_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [BUS_W-1:0]  bus_wdata_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        fam_o,
    input logic [7:0]        sectors_o,
    input logic [SIZE_W-1:0] size_o,
    input logic              boot_o
);
    logic [31:0] since_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_sel <= '0;
        end else if (bus_we_o && bus_wdata_o[7:0] == 8'h90) begin
            since_sel <= '0;
        end else if (since_sel != 32'hFFFF_FFFF) begin
            since_sel <= since_sel + 1;
        end
    end

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_we_o && bus_re_o));

    p_cmd_lanes_r2: assert property (@(posedge clk) disable iff (rst)
        bus_we_o |-> (bus_wdata_o == {BUS_W/16{8'h00, bus_wdata_o[7:0]}}));

    p_settle_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_re_o && bus_addr_o == '0) |-> (since_sel == 32'(SETTLE_CYC)));

    p_unknown_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && fam_o == 2'd0) |-> (size_o == '0 && sectors_o == '0 && !boot_o));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(fam_o) && $stable(sectors_o) && $stable(size_o) && $stable(boot_o)));

    p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

endmodule

bind nor_id_probe nor_id_probe_chk #(
    .BUS_W      (BUS_W),
    .ADDR_W     (ADDR_W),
    .SETTLE_CYC (SETTLE_CYC),
    .SIZE_W     (SIZE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_we_o    (bus_we_o),
    .bus_re_o    (bus_re_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fam_o       (fam_o),
    .sectors_o   (sectors_o),
    .size_o      (size_o),
    .boot_o      (boot_o)
);

// File: tb/nor_id_probe_tb.sv
module nor_id_probe_tb;
    localparam int BW = 16;
    localparam int AW = 24;
    localparam int ST = 16;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] addr;
    logic [BW-1:0] wdata;
    logic [BW-1:0] rdata = '0;
    logic          we, re, busy, done, boot;
    logic [1:0]    fam;
    logic [7:0]    sec;
    logic [SW-1:0] size;

    always #10 clk = ~clk;

    nor_id_probe #(.BUS_W(BW), .ADDR_W(AW), .SETTLE_CYC(ST), .SIZE_W(SW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start),
        .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
        .bus_we_o(we), .bus_re_o(re), .busy_o(busy), .done_o(done),
        .fam_o(fam), .sectors_o(sec), .size_o(size), .boot_o(boot)
    );

    // Flash model: enters ID mode on 0x90, leaves it on 0xF0/0xFF; read data one cycle after strobe
    logic        id_mode = 1'b0;
    logic [15:0] mfr_w = 16'h0001;
    logic [15:0] dev_w = 16'h22D7;

    always @(posedge clk) begin
        if (we) begin
            if (wdata[7:0] == 8'h90) id_mode <= 1'b1;
            if (wdata[7:0] == 8'hF0 || wdata[7:0] == 8'hFF) id_mode <= 1'b0;
        end
        if (re) begin
            if (!id_mode)       rdata <= 16'hFFFF;
            else if (addr == 0) rdata <= mfr_w;
            else if (addr == 1) rdata <= dev_w;
            else                rdata <= 16'h0000;
        end
    end

    typedef struct {
        bit            wr;
        logic [AW-1:0] a;
        logic [BW-1:0] d;
        string         tag;
    } bus_ev_t;

    typedef struct {
        logic [1:0]    fam;
        logic [7:0]    sec;
        logic [SW-1:0] size;
        logic          boot;
        string         tag;
    } res_t;

    bus_ev_t bq[$];
    res_t    rq[$];
    res_t    last_exp;
    int      n_chk = 0;
    int      n_fail = 0;
    int      n_res = 0;
    longint  cyc = 0;
    longint  t_sel = 0;
    bit      prev_busy = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_ev(input bit wr, input int a, input logic [7:0] b, input string tag);
        bus_ev_t e;
        e.wr = wr; e.a = AW'(a); e.d = {8'h00, b}; e.tag = tag;
        bq.push_back(e);
    endtask

    // Expected behaviour built from the requirements
    task automatic expect_probe(input logic [15:0] m, input logic [15:0] d, input string tag);
        res_t r;
        logic [1:0] f;
        bit hit;
        int lg;
        r.fam = 0; r.sec = 0; r.size = 0; r.boot = 0; r.tag = tag;
        hit = 0; lg = 0;
        push_ev(1, 'h555, 8'hAA, "R2");
        push_ev(1, 'h2AA, 8'h55, "R2");
        push_ev(1, 'h555, 8'h90, "R2");
        push_ev(0, 0, 8'h00, "R4");
        f = (m[7:0] == 8'h01) ? 2'd1 : (m[7:0] == 8'h89) ? 2'd2 : 2'd0;
        if (f != 0) begin
            push_ev(0, 1, 8'h00, "R6");
            hit = 1;
            case (d)
                16'h22D7: begin r.sec = 128; lg = 23; r.boot = 0; end
                16'h88C1: begin r.sec = 23;  lg = 20; r.boot = 1; end
                16'h88C2: begin r.sec = 39;  lg = 21; r.boot = 1; end
                16'h88C3: begin r.sec = 71;  lg = 22; r.boot = 1; end
                16'h88C4: begin r.sec = 135; lg = 23; r.boot = 1; end
                default:  hit = 0;
            endcase
            if (hit) begin
                r.fam  = f;
                r.size = SW'(1) << lg;
                push_ev(1, 0, (f == 2'd2) ? 8'hFF : 8'hF0, "R8");
            end else begin
                r.sec = 0; r.boot = 0;
            end
        end
        rq.push_back(r);
        last_exp = r;
    endtask

    task automatic check_hold(input string tag);
        repeat (6) @(negedge clk);
        chk(fam == last_exp.fam,   tag, "held family",  fam,  last_exp.fam);
        chk(sec == last_exp.sec,   tag, "held sectors", sec,  last_exp.sec);
        chk(size == last_exp.size, tag, "held size",    size, last_exp.size);
        chk(!busy && !done,        tag, "idle after done", {busy, done}, 0);
    endtask

    task automatic run(input logic [15:0] m, input logic [15:0] d,
                       input string tag, input bit mid_start);
        int target;
        mfr_w = m;
        dev_w = d;
        target = n_res + 1;
        expect_probe(m, d, tag);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (mid_start) begin
            repeat (8) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(busy == 1'b1, "R10", "still busy after start while busy", busy, 1);
        end
        wait (n_res == target);
        check_hold("R9");
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (we || re) begin
                if (bq.size() == 0) begin
                    chk(0, "R5", "unexpected strobe at address", addr, 0);
                end else begin
                    bus_ev_t e;
                    e = bq.pop_front();
                    chk(we == e.wr, e.tag, "strobe kind (1=write)", we, e.wr);
                    chk(addr == e.a, e.tag, "address", addr, e.a);
                    if (we) chk(wdata == e.d, e.tag, "write data", wdata, e.d);
                end
            end
            if (we && wdata[7:0] == 8'h90) t_sel = cyc;
            if (re && addr == 0)
                chk(cyc - t_sel == ST + 1, "R3", "settle gap", cyc - t_sel, ST + 1);
            if (done) begin
                chk(!busy && prev_busy, "R9", "busy low at done, high before",
                    {prev_busy, busy}, 2'b10);
                if (rq.size() == 0) begin
                    chk(0, "R9", "unexpected done", 1, 0);
                end else begin
                    res_t r;
                    r = rq.pop_front();
                    chk(fam == r.fam,   r.tag, "family",  fam,  r.fam);
                    chk(sec == r.sec,   r.tag, "sectors", sec,  r.sec);
                    chk(size == r.size, r.tag, "size",    size, r.size);
                    chk(boot == r.boot, r.tag, "boot",    boot, r.boot);
                end
                n_res++;
            end
            prev_busy = busy;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got %0d results expected more", n_res);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: auto probe after reset, unlock-cycle family uniform part
        expect_probe(16'h0001, 16'h22D7, "R1");
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
        chk(!done && !we && !re, "R1", "done/strobes in reset", {done, we, re}, 0);
        chk(fam == 0 && sec == 0 && size == 0 && !boot, "R1", "results in reset", size, 0);
        rst = 1'b0;
        wait (n_res == 1);
        check_hold("R9");

        // R4: upper byte of manufacturer word ignored; R8 status family reset byte
        run(16'hAB89, 16'h88C1, "R4", 1'b0);
        // R10: start while busy ignored
        run(16'h0089, 16'h88C4, "R10", 1'b1);
        run(16'h0001, 16'h88C2, "R6", 1'b0);
        run(16'h0089, 16'h88C3, "R8", 1'b0);
        // R5: unknown vendor
        run(16'h0020, 16'h22D7, "R5", 1'b0);
        // R7: unmatched device code, and a near miss
        run(16'h0001, 16'h1234, "R7", 1'b0);
        run(16'h0089, 16'h22D6, "R7", 1'b0);
        // R6: back to a known part after unknown results
        run(16'h0001, 16'h22D7, "R6", 1'b0);

        chk(bq.size() == 0, "R5", "leftover expected bus events", bq.size(), 0);
        chk(rq.size() == 0, "R9", "leftover expected results", rq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule